// File: doc/BRIEF.md
# ISA I/O Slave Register Interface

This block is an 8-bit I/O-mapped slave on an ISA host bus. It compares the upper address lines against a 6-bit base setting taken from a switch. On a match, the low four address lines pick one of sixteen internal registers. Host writes are latched into the chosen register, and host reads get its contents on the data bus. The strobes pass through two-flop synchronizers into the system clock domain, and all edges are detected in that domain.

Two registers lead to a far-side peer. Writing the outbound register starts a transfer to the peer. Reading the inbound register starts a fetch from the peer. For either transfer, the block pulls the open-drain channel-ready line low until the peer acknowledges. If no acknowledge arrives within a bounded number of clocks, the block releases the line anyway and flags a timeout.

A sticky status register collects completion, timeout and external event bits. Each status bit is cleared by writing 1 to its position. An enable register masks the status bits onto the interrupt output.

Top module: `isa_reg_slave`

## Requirements
- R1: The block responds only when `csN` is low and `addr[9:4]` equals `swBase`. Any other cycle leaves every register unchanged and keeps `dataOe` low.
- R2: During a matched cycle with `iorN` low, `dataOe` is high and `dataOut` carries the register selected by `addr[3:0]`. At all other times `dataOe` is low.
- R3: Register map, selected by `addr[3:0]`:
  - 0 is status.
  - 1 is interrupt enable.
  - 2 is the outbound far register.
  - 3 is the inbound far register.
  - 4 to 15 are scratch registers.

  A write to 1, 2 or 4 to 15 reads back as the written value.
- R4: A write takes effect when the synchronized `iowN` rises, no later than the third clock edge after the pin rises. The host holds address, `csN` and data for four clocks after `iowN` rises.
- R5: A matched `iowN` assertion to register 2 does the following:
  - loads `dataIn` into `farWdata`;
  - raises `farReq` with `farWrite` = 1;
  - holds `rdyPullLow` high until `farAck` is seen, which also sets status bit 0.
- R6: A matched `iorN` assertion to register 3 does the following:
  - raises `farReq` with `farWrite` = 0;
  - holds `rdyPullLow` high until `farAck` is seen;
  - on `farAck`, captures `farRdata` into register 3, so that the same read returns it, and sets status bit 0.
- R7: With no `farAck`, `rdyPullLow` is held for exactly TIMEOUT clocks (default 1024), then released. At release `farReq` drops and status bit 1 sets.
- R8: `irqSrc[i]` sampled high at a clock edge sets status bit i+2.
- R9: Writing 1 to a status bit clears it, and a 0 leaves it unchanged. A set arriving in the same cycle wins over the clear.
- R10: `intr` is high exactly when the bitwise AND of status and enable is nonzero.
- R11: Register 3 ignores host writes. A far read that times out returns the previous contents of register 3 unchanged.
- R12: `isaReset` high clears every register and brings `rdyPullLow`, `farReq`, `dataOe` and `intr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| isaReset | input | 1 | Asynchronous hard reset, active high |
| swBase | input | 6 | Base address switch setting |
| csN | input | 1 | Chip select, active low |
| addr | input | 10 | I/O address, bits 9..4 base and 3..0 register |
| iorN | input | 1 | I/O read strobe, active low |
| iowN | input | 1 | I/O write strobe, active low |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data |
| dataOe | output | 1 | Data bus drive enable |
| rdyPullLow | output | 1 | 1 pulls channel-ready low (open-drain wait) |
| intr | output | 1 | Interrupt request |
| irqSrc | input | 6 | Event inputs setting status bits 7..2 |
| farReq | output | 1 | Far-side transfer request |
| farWrite | output | 1 | Direction of far transfer, 1 = outbound |
| farWdata | output | 8 | Outbound byte to far side |
| farRdata | input | 8 | Inbound byte from far side |
| farAck | input | 1 | Far-side acknowledge |

## Verification
The assertions take several things for granted about the host side:
- Address, `csN` and write data stay stable from before a strobe falls until four clocks after it rises.
- `iorN` and `iowN` are never low together.
- Each strobe stays low for at least three clocks, and stays high long enough between cycles for the synchronizers to settle.
- `farAck` arrives only while `farReq` is high.

The bench drives every host cycle through tasks that sequence address, select, data and strobe with these margins. Its far-side responder acknowledges only an open request, and only after a delay.

// File: rtl/isa_reg_pkg.sv
package isa_reg_pkg;
  localparam int unsigned SEL_W = 4;
  localparam int unsigned NREG = 1 << SEL_W;
  localparam logic [SEL_W-1:0] REG_STATUS = 4'd0;
  localparam logic [SEL_W-1:0] REG_ENABLE = 4'd1;
  localparam logic [SEL_W-1:0] REG_FAR_OUT = 4'd2;
  localparam logic [SEL_W-1:0] REG_FAR_IN = 4'd3;
  localparam int unsigned FIRST_SCR = 4;

  typedef struct packed {
    logic wrCommit;
    logic [SEL_W-1:0] wrIdx;
    logic ldFarOut;
    logic ldFarIn;
    logic setDone;
    logic setTimeout;
  } ctrl_strobe_t;
endpackage

// File: rtl/isa_reg_ctrl.sv
module isa_reg_ctrl
  import isa_reg_pkg::*;
#(
  parameter int SW_W = 6,
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic [SW_W-1:0] swBase,
  input  logic csN,
  input  logic [SW_W+SEL_W-1:0] addr,
  input  logic iorN,
  input  logic iowN,
  input  logic farAck,
  output logic farReq,
  output logic farWrite,
  output logic waitPull,
  output logic dataOe,
  output ctrl_strobe_t strb
);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic {ST_IDLE, ST_BUSY} state_t;

  state_t state;
  logic [TW-1:0] timer;
  logic [2:0] iowSync, iorSync;
  logic iowFall, iowRise, iorFall;
  logic match, startWr, startRd, timeoutHit;
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      iowSync <= '1;
      iorSync <= '1;
    end else begin
      iowSync <= {iowSync[1:0], iowN};
      iorSync <= {iorSync[1:0], iorN};
    end
  end

  assign iowFall = iowSync[2] & ~iowSync[1];
  assign iowRise = ~iowSync[2] & iowSync[1];
  assign iorFall = iorSync[2] & ~iorSync[1];

  assign match = !csN && (addr[SW_W+SEL_W-1:SEL_W] == swBase);
  assign idx = addr[SEL_W-1:0];
  assign dataOe = match && !iorN;

  assign startWr = (state == ST_IDLE) && iowFall && match && (idx == REG_FAR_OUT);
  assign startRd = (state == ST_IDLE) && iorFall && match && (idx == REG_FAR_IN);
  assign timeoutHit = (state == ST_BUSY) && !farAck && (timer == TW'(TIMEOUT - 1));

  always_comb begin
    strb = '0;
    strb.wrCommit = iowRise && match;
    strb.wrIdx = idx;
    strb.ldFarOut = startWr;
    strb.setDone = (state == ST_BUSY) && farAck;
    strb.ldFarIn = (state == ST_BUSY) && farAck && !farWrite;
    strb.setTimeout = timeoutHit;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE;
      timer <= '0;
      farWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          timer <= '0;
          if (startWr) begin
            state <= ST_BUSY;
            farWrite <= 1'b1;
          end else if (startRd) begin
            state <= ST_BUSY;
            farWrite <= 1'b0;
          end
        end
        default: begin
          timer <= timer + 1'b1;
          if (farAck || timeoutHit) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign waitPull = (state == ST_BUSY);
  assign farReq = (state == ST_BUSY);

  // R5: a far write start holds the cycle and points the request outward
  a_r5_start_holds: assert property (@(posedge clk) disable iff (rst)
    strb.ldFarOut |=> (waitPull && farWrite));
  // R5 / R6: an acknowledge ends the wait
  a_r5_ack_releases: assert property (@(posedge clk) disable iff (rst)
    (waitPull && farAck) |=> !waitPull);
  // R7: the hold never outlasts the timeout window
  a_r7_timeout_release: assert property (@(posedge clk) disable iff (rst)
    (waitPull && timer == TW'(TIMEOUT - 1)) |=> !waitPull);
endmodule

// File: rtl/isa_reg_dp.sv
module isa_reg_dp
  import isa_reg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst,
  input  ctrl_strobe_t strb,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-3:0] irqSrc,
  input  logic [SEL_W-1:0] rdIdx,
  input  logic [DW-1:0] farRdata,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] farWdata,
  output logic intr
);
  localparam int NSCR = NREG - FIRST_SCR;

  logic [DW-1:0] statusReg, enableReg, farOut, farIn;
  logic [DW-1:0] setMask, clrMask;
  logic [DW-1:0] scratch [NSCR];

  assign setMask = {irqSrc, strb.setTimeout, strb.setDone};
  assign clrMask = (strb.wrCommit && strb.wrIdx == REG_STATUS) ? dataIn : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      statusReg <= '0;
      enableReg <= '0;
      farOut <= '0;
      farIn <= '0;
    end else begin
      statusReg <= (statusReg & ~clrMask) | setMask;
      if (strb.wrCommit && strb.wrIdx == REG_ENABLE) enableReg <= dataIn;
      if (strb.ldFarOut || (strb.wrCommit && strb.wrIdx == REG_FAR_OUT)) farOut <= dataIn;
      if (strb.ldFarIn) farIn <= farRdata;
    end
  end

  for (genvar g = 0; g < NSCR; g++) begin : g_scr
    always_ff @(posedge clk or posedge rst) begin
      if (rst) scratch[g] <= '0;
      else if (strb.wrCommit && strb.wrIdx == SEL_W'(g + FIRST_SCR)) scratch[g] <= dataIn;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdIdx)
      REG_STATUS:  rdData = statusReg;
      REG_ENABLE:  rdData = enableReg;
      REG_FAR_OUT: rdData = farOut;
      REG_FAR_IN:  rdData = farIn;
      default: begin
        for (int k = 0; k < NSCR; k++)
          if (rdIdx == SEL_W'(k + FIRST_SCR)) rdData = scratch[k];
      end
    endcase
  end

  assign farWdata = farOut;
  assign intr = |(statusReg & enableReg);

  // R3: an enable write lands with the host data
  a_r3_enable_write: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCommit && strb.wrIdx == REG_ENABLE) |=> (enableReg == $past(dataIn)));
  // R7: a timeout leaves its flag set
  a_r7_timeout_flag: assert property (@(posedge clk) disable iff (rst)
    strb.setTimeout |=> statusReg[1]);
  // R9: write-one clears the done bit unless it is set again
  a_r9_w1c_done: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCommit && strb.wrIdx == REG_STATUS && dataIn[0] && !strb.setDone) |=> !statusReg[0]);
  // R11: host writes never reach the inbound register
  a_r11_farin_ro: assert property (@(posedge clk) disable iff (rst)
    (strb.wrCommit && strb.wrIdx == REG_FAR_IN && !strb.ldFarIn) |=> $stable(farIn));
endmodule

// File: rtl/isa_reg_slave.sv
module isa_reg_slave
  import isa_reg_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW_W = 6,
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic isaReset,
  input  logic [SW_W-1:0] swBase,
  input  logic csN,
  input  logic [SW_W+SEL_W-1:0] addr,
  input  logic iorN,
  input  logic iowN,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic dataOe,
  output logic rdyPullLow,
  output logic intr,
  input  logic [DW-3:0] irqSrc,
  output logic farReq,
  output logic farWrite,
  output logic [DW-1:0] farWdata,
  input  logic [DW-1:0] farRdata,
  input  logic farAck
);
  ctrl_strobe_t strb;
  logic [DW-1:0] rdData;

  isa_reg_ctrl #(.SW_W(SW_W), .TIMEOUT(TIMEOUT)) i_ctrl (
    .clk(clk), .rst(isaReset), .swBase(swBase), .csN(csN), .addr(addr),
    .iorN(iorN), .iowN(iowN), .farAck(farAck), .farReq(farReq),
    .farWrite(farWrite), .waitPull(rdyPullLow), .dataOe(dataOe), .strb(strb)
  );

  isa_reg_dp #(.DW(DW)) i_dp (
    .clk(clk), .rst(isaReset), .strb(strb), .dataIn(dataIn), .irqSrc(irqSrc),
    .rdIdx(addr[SEL_W-1:0]), .farRdata(farRdata), .rdData(rdData),
    .farWdata(farWdata), .intr(intr)
  );

  assign dataOut = dataOe ? rdData : '0;
endmodule

// File: tb/test_isa_reg_slave.sv
module test_isa_reg_slave;
  localparam int TIMEOUT = 1024;
  localparam logic [5:0] BASE = 6'b011001;

  logic clk = 1'b0, isaReset = 1'b1, csN = 1'b1, iorN = 1'b1, iowN = 1'b1, farAck = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] dataIn = '0, farRdata = '0;
  logic [5:0] irqSrc = '0;
  logic [7:0] dataOut, farWdata;
  logic dataOe, rdyPullLow, intr, farReq, farWrite;

  int errs = 0, checks = 0;
  bit respondEn = 1'b1, finished = 1'b0;
  logic [7:0] nextRd = '0, lastWdata = '0;
  logic lastWrite = 1'b0;
  logic [7:0] model [16];

  isa_reg_slave i_isa_reg_slave (
    .clk(clk), .isaReset(isaReset), .swBase(BASE), .csN(csN), .addr(addr),
    .iorN(iorN), .iowN(iowN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rdyPullLow(rdyPullLow), .intr(intr), .irqSrc(irqSrc), .farReq(farReq),
    .farWrite(farWrite), .farWdata(farWdata), .farRdata(farRdata), .farAck(farAck)
  );

  initial forever #10 clk = ~clk;

  function automatic logic [9:0] regAddr(input logic [5:0] base, input int idx);
    return {base, 4'(idx)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic isaWrite(input logic [9:0] a, input logic [7:0] d, input logic cs, output int busy);
    @(negedge clk); addr = a; dataIn = d; csN = cs;
    @(negedge clk); iowN = 1'b0; busy = 0;
    repeat (3) begin @(negedge clk); if (rdyPullLow) busy++; end
    while (rdyPullLow) begin @(negedge clk); if (rdyPullLow) busy++; end
    @(negedge clk); iowN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic isaRead(input logic [9:0] a, input logic cs, output logic [7:0] d,
                         output logic oe, output int busy);
    @(negedge clk); addr = a; csN = cs;
    @(negedge clk); iorN = 1'b0; busy = 0;
    repeat (3) begin @(negedge clk); if (rdyPullLow) busy++; end
    while (rdyPullLow) begin @(negedge clk); if (rdyPullLow) busy++; end
    d = dataOut; oe = dataOe;
    @(negedge clk); iorN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
  endtask

  // far-side responder
  initial forever begin
    @(negedge clk);
    if (farReq && respondEn) begin
      repeat (3) @(negedge clk);
      lastWdata = farWdata; lastWrite = farWrite;
      farRdata = nextRd; farAck = 1'b1;
      @(negedge clk); farAck = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    int busy;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R12 reset rdyPullLow", rdyPullLow, 0);
    check("R12 reset farReq", farReq, 0);
    check("R12 reset intr", intr, 0);
    check("R12 reset dataOe", dataOe, 0);
    isaReset = 1'b0;
    repeat (2) @(negedge clk);

    isaRead(regAddr(BASE, 0), 1'b0, rd, oe, busy);
    check("R12 status zero after reset", rd, 0);
    check("R2 oe on matched read", oe, 1);

    // R3 R4: random scratch traffic
    for (int i = 0; i < 40; i++) begin
      int idx = 4 + $urandom_range(11);
      logic [7:0] d = 8'($urandom);
      isaWrite(regAddr(BASE, idx), d, 1'b0, busy);
      model[idx] = d;
      check("R4 plain write no wait", busy, 0);
    end
    for (int idx = 4; idx < 16; idx++) begin
      isaRead(regAddr(BASE, idx), 1'b0, rd, oe, busy);
      check("R3 scratch readback", rd, model[idx]);
    end
    isaWrite(regAddr(BASE, 1), 8'h00, 1'b0, busy);
    isaRead(regAddr(BASE, 1), 1'b0, rd, oe, busy);
    check("R3 enable readback", rd, 8'h00);

    // R1: base mismatch and chip select high are ignored
    isaWrite(regAddr(BASE ^ 6'b000100, 5), ~model[5], 1'b0, busy);
    isaWrite(regAddr(BASE, 6), ~model[6], 1'b1, busy);
    isaRead(regAddr(BASE, 5), 1'b0, rd, oe, busy);
    check("R1 mismatched base write ignored", rd, model[5]);
    isaRead(regAddr(BASE, 6), 1'b0, rd, oe, busy);
    check("R1 csN high write ignored", rd, model[6]);
    isaRead(regAddr(BASE ^ 6'b100000, 5), 1'b0, rd, oe, busy);
    check("R1 R2 no drive on mismatch", oe, 0);

    // R5: far write
    isaWrite(regAddr(BASE, 2), 8'hC3, 1'b0, busy);
    check("R5 far write held", busy > 0, 1);
    check("R5 far write data", lastWdata, 8'hC3);
    check("R5 far write direction", lastWrite, 1);
    isaRead(regAddr(BASE, 2), 1'b0, rd, oe, busy);
    check("R3 outbound readback", rd, 8'hC3);
    isaRead(regAddr(BASE, 0), 1'b0, rd, oe, busy);
    check("R5 done bit", rd, 8'h01);

    // R6: far read
    nextRd = 8'h96;
    isaRead(regAddr(BASE, 3), 1'b0, rd, oe, busy);
    check("R6 far read data", rd, 8'h96);
    check("R6 far read held", busy > 0, 1);
    check("R6 far read direction", lastWrite, 0);

    // R7: timeouts, R11: inbound register read-only
    respondEn = 1'b0;
    isaWrite(regAddr(BASE, 2), 8'h11, 1'b0, busy);
    check("R7 write timeout length", busy, TIMEOUT);
    check("R7 request dropped", farReq, 0);
    isaWrite(regAddr(BASE, 3), 8'h5A, 1'b0, busy);
    nextRd = 8'h77;
    isaRead(regAddr(BASE, 3), 1'b0, rd, oe, busy);
    check("R7 read timeout length", busy, TIMEOUT);
    check("R11 inbound unchanged", rd, 8'h96);
    respondEn = 1'b1;
    isaRead(regAddr(BASE, 0), 1'b0, rd, oe, busy);
    check("R7 timeout bit", rd, 8'h03);

    // R10 R9: interrupt masking and write-one-clear
    check("R10 masked intr low", intr, 0);
    isaWrite(regAddr(BASE, 1), 8'h02, 1'b0, busy);
    check("R10 enabled intr high", intr, 1);
    isaWrite(regAddr(BASE, 0), 8'h02, 1'b0, busy);
    isaRead(regAddr(BASE, 0), 1'b0, rd, oe, busy);
    check("R9 clear only written bit", rd, 8'h01);
    check("R10 intr low after clear", intr, 0);
    isaWrite(regAddr(BASE, 0), 8'hFF, 1'b0, busy);

    // R8: event sources
    for (int i = 0; i < 6; i++) begin
      logic [5:0] p = 6'($urandom) | 6'b1;
      isaWrite(regAddr(BASE, 1), 8'(p) << 2, 1'b0, busy);
      @(negedge clk); irqSrc = p;
      @(negedge clk); irqSrc = '0;
      @(negedge clk);
      check("R10 event intr", intr, 1);
      isaRead(regAddr(BASE, 0), 1'b0, rd, oe, busy);
      check("R8 event bits", rd, {p, 2'b00});
      isaWrite(regAddr(BASE, 0), 8'hFF, 1'b0, busy);
      check("R9 full clear intr", intr, 0);
    end

    // R12: reset mid-run
    isaWrite(regAddr(BASE, 1), 8'h80, 1'b0, busy);
    @(negedge clk); isaReset = 1'b1;
    repeat (2) @(negedge clk); isaReset = 1'b0;
    isaRead(regAddr(BASE, 9), 1'b0, rd, oe, busy);
    check("R12 scratch cleared", rd, 0);
    isaRead(regAddr(BASE, 1), 1'b0, rd, oe, busy);
    check("R12 enable cleared", rd, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule